// File: doc/BRIEF.md
# Data Watchpoint Match Unit

This block implements one hardware data watchpoint for a processor debug unit. Software programs two registers through a simple write port: a value register, which holds the watched address, and a control register, which holds the enable, the qualifiers, the byte-lane select, the address-range mask and the link settings. Each cycle the block may receive one memory access. An access carries its byte address, the byte lanes it touches within the enclosing doubleword, load and store flags, and a privilege flag. When every programmed condition holds, the block raises a single-cycle event pulse on the clock edge that follows the access.

The block compares addresses in one of two modes. In byte-select mode the doubleword address must be equal and at least one touched lane must be selected. In range mode a power-of-two mask removes low address bits from the comparison. The block can also be linked to one external context breakpoint. It drives the number of that breakpoint on an output, and when linking is on it requires a match flag from that breakpoint. Reserved encodings never match, so the behaviour is always defined.

Top module: `data_watchpoint`

## Requirements
- R1: After reset, both registers are zero, `wp_event` is 0 and `link_bp_sel` is 0.
- R2: Control bit 0 enables the watchpoint. While it is 0, `wp_event` stays 0 for any access.
- R3: Privilege field, control bits 2:1. Code 01 matches only when `acc_priv`=1, code 10 matches only when `acc_priv`=0, code 11 matches either, and code 00 never matches.
- R4: Access-type field, control bits 4:3. Code 01 needs `acc_load`, code 10 needs `acc_store`, code 11 needs either, and code 00 never matches. A swap raises both flags.
- R5: Byte-select mode applies when the mask field is 0. Bits 31:3 of the access address must equal bits 31:3 of the value register. `acc_lanes[k]` means byte k of that doubleword is touched. When value bit 2 is 0, select bits 7:0 (control bits 12:5) apply to lanes 7:0. When value bit 2 is 1, select bits 3:0 apply to lanes 7:4. The access hits if any touched lane is selected.
- R6: An all-zero byte select never matches.
- R7: Range mode uses the mask field, control bits 28:24. A value n from 3 to 31 compares only address bits 31:n, needs the byte select at 8'hFF, and needs `acc_lanes` to be nonzero. Mask values 1 and 2, or any nonzero mask with a byte select other than 8'hFF, never match.
- R8: When the link bit (control bit 20) is 1, an event also requires `link_match`=1.
- R9: `link_bp_sel` shows control bits 19:16 from the cycle after the control write.
- R10: `wp_event` is high for exactly the one cycle after a matching access with `acc_valid`=1. It is 0 after a cycle with no valid access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 value register, 1 control register |
| reg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Access byte address |
| acc_lanes | input | 8 | Touched byte lanes of the enclosing doubleword |
| acc_load | input | 1 | Access reads memory |
| acc_store | input | 1 | Access writes memory |
| acc_priv | input | 1 | Access is privileged |
| link_match | input | 1 | Linked context breakpoint currently matches |
| link_bp_sel | output | 4 | Number of the linked context breakpoint |
| wp_event | output | 1 | Watchpoint event pulse |

## Verification
A register write drives its inputs after a falling edge, takes effect on the next rising edge, and is visible on `link_bp_sel` at the falling edge that follows. An access follows the same pattern, so its event is due one rising edge after it is presented. The bench samples at the falling edge after that, when it also drops `acc_valid`. It checks once more one cycle later that the pulse has gone. Every expected value comes from a bench function that holds a shadow copy of the written registers.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

    // decoded control register fields
    typedef struct packed {
        logic [4:0] mask_n;
        logic       link_en;
        logic [3:0] link_bp;
        logic [7:0] bsel;
        logic [1:0] ls;
        logic [1:0] priv;
        logic       en;
    } wpt_ctrl_t;

    localparam int unsigned CTRL_W      = 32;
    localparam int unsigned MIN_MASK_N  = 3;
    localparam logic [1:0]  CODE_NONE   = 2'b00;
    localparam logic [1:0]  CODE_FIRST  = 2'b01;
    localparam logic [1:0]  CODE_SECOND = 2'b10;
    localparam logic [1:0]  CODE_BOTH   = 2'b11;

    function automatic wpt_ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] w);
        wpt_ctrl_t c;
        c.en      = w[0];
        c.priv    = w[2:1];
        c.ls      = w[4:3];
        c.bsel    = w[12:5];
        c.link_bp = w[19:16];
        c.link_en = w[20];
        c.mask_n  = w[28:24];
        return c;
    endfunction

endpackage

// File: rtl/wpt_regs.sv
module wpt_regs
    import wpt_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [AW-1:0]     value_q,
    output wpt_ctrl_t         ctrl_q
);

    logic ctrl_unused_bits;
    assign ctrl_unused_bits = ^{reg_wdata[31:29], reg_wdata[23:21], reg_wdata[15:13]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
            ctrl_q  <= '0;
        end else if (reg_we) begin
            if (reg_sel) ctrl_q  <= unpack_ctrl(reg_wdata);
            else         value_q <= reg_wdata[AW-1:0];
        end
    end

endmodule

// File: rtl/wpt_addr_cmp.sv
module wpt_addr_cmp
    import wpt_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned LANES = 8
) (
    input  logic [AW-1:0]    value_q,
    input  logic [AW-1:0]    acc_addr,
    input  logic [LANES-1:0] acc_lanes,
    input  logic [LANES-1:0] bsel,
    input  logic [4:0]       mask_n,
    output logic             addr_hit
);

    localparam int unsigned HALF = LANES / 2;
    localparam int unsigned LSB  = $clog2(LANES);

    logic [AW-1:0]    diff;
    logic [AW-1:0]    keep;
    logic [LANES-1:0] sel_eff;

    always_comb begin
        diff = acc_addr ^ value_q;
        for (int i = 0; i < int'(AW); i++) begin
            keep[i] = (i >= int'(mask_n));
        end
        sel_eff = value_q[LSB-1] ? {bsel[HALF-1:0], {HALF{1'b0}}} : bsel;
        if (mask_n == '0) begin
            addr_hit = (diff[AW-1:LSB] == '0) && (|(sel_eff & acc_lanes));
        end else if ((int'(mask_n) < int'(MIN_MASK_N)) || (bsel != {LANES{1'b1}})) begin
            addr_hit = 1'b0;
        end else begin
            addr_hit = ((diff & keep) == '0) && (|acc_lanes);
        end
    end

endmodule

// File: rtl/wpt_qual.sv
module wpt_qual
    import wpt_pkg::*;
(
    input  logic [1:0] ls,
    input  logic [1:0] priv,
    input  logic       acc_load,
    input  logic       acc_store,
    input  logic       acc_priv,
    output logic       qual_ok
);

    logic type_ok;
    logic priv_ok;

    always_comb begin
        unique case (ls)
            CODE_FIRST:  type_ok = acc_load;
            CODE_SECOND: type_ok = acc_store;
            CODE_BOTH:   type_ok = acc_load | acc_store;
            default:     type_ok = 1'b0;
        endcase
        unique case (priv)
            CODE_FIRST:  priv_ok = acc_priv;
            CODE_SECOND: priv_ok = !acc_priv;
            CODE_BOTH:   priv_ok = 1'b1;
            default:     priv_ok = 1'b0;
        endcase
        qual_ok = type_ok & priv_ok;
    end

endmodule

// File: rtl/data_watchpoint.sv
module data_watchpoint
    import wpt_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned LANES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [31:0]      reg_wdata,
    input  logic             acc_valid,
    input  logic [AW-1:0]    acc_addr,
    input  logic [LANES-1:0] acc_lanes,
    input  logic             acc_load,
    input  logic             acc_store,
    input  logic             acc_priv,
    input  logic             link_match,
    output logic [3:0]       link_bp_sel,
    output logic             wp_event
);

    logic [AW-1:0] value_q;
    wpt_ctrl_t     ctrl_q;
    logic          addr_hit;
    logic          qual_ok;
    logic          link_ok;
    logic          hit_now;

    wpt_regs #(.AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .value_q  (value_q),
        .ctrl_q   (ctrl_q)
    );

    wpt_addr_cmp #(.AW(AW), .LANES(LANES)) u_addr (
        .value_q  (value_q),
        .acc_addr (acc_addr),
        .acc_lanes(acc_lanes),
        .bsel     (ctrl_q.bsel),
        .mask_n   (ctrl_q.mask_n),
        .addr_hit (addr_hit)
    );

    wpt_qual u_qual (
        .ls       (ctrl_q.ls),
        .priv     (ctrl_q.priv),
        .acc_load (acc_load),
        .acc_store(acc_store),
        .acc_priv (acc_priv),
        .qual_ok  (qual_ok)
    );

    always_comb begin
        link_ok = !ctrl_q.link_en || link_match;
        hit_now = acc_valid && ctrl_q.en && addr_hit && qual_ok && link_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wp_event <= 1'b0;
        else        wp_event <= hit_now;
    end

    assign link_bp_sel = ctrl_q.link_bp;

endmodule

// File: rtl/wpt_chk.sv
module wpt_chk
    import wpt_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic        reg_sel,
    input logic [31:0] reg_wdata,
    input logic        acc_valid,
    input logic        acc_priv,
    input logic        link_match,
    input wpt_ctrl_t   ctrl_q,
    input logic [3:0]  link_bp_sel,
    input logic        wp_event
);

    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.en |=> !wp_event);

    // R3
    priv_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.priv == CODE_FIRST && !acc_priv) |=> !wp_event);

    // R4
    type_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.ls == CODE_NONE) |=> !wp_event);

    // R8
    link_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.link_en && !link_match) |=> !wp_event);

    // R9
    link_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel) |=> (link_bp_sel == $past(reg_wdata[19:16])));

    // R10
    no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !wp_event);

endmodule

bind data_watchpoint wpt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .acc_valid  (acc_valid),
    .acc_priv   (acc_priv),
    .link_match (link_match),
    .ctrl_q     (ctrl_q),
    .link_bp_sel(link_bp_sel),
    .wp_event   (wp_event)
);

// File: tb/data_watchpoint_test.sv
`timescale 1ns/1ps
module data_watchpoint_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [7:0]  acc_lanes = '0;
    logic        acc_load = 1'b0;
    logic        acc_store = 1'b0;
    logic        acc_priv = 1'b0;
    logic        link_match = 1'b0;
    logic [3:0]  link_bp_sel;
    logic        wp_event;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [31:0] m_val = '0;
    logic [31:0] m_ctrl = '0;

    always #2.5 clk = ~clk;

    data_watchpoint uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_lanes(acc_lanes), .acc_load(acc_load), .acc_store(acc_store),
        .acc_priv(acc_priv), .link_match(link_match),
        .link_bp_sel(link_bp_sel), .wp_event(wp_event)
    );

    function automatic logic [31:0] mk_ctrl(bit en, logic [1:0] pv, logic [1:0] ls,
                                            logic [7:0] bs, logic [3:0] lbp, bit le,
                                            logic [4:0] mk);
        return {3'b0, mk, 3'b0, le, lbp, 3'b0, bs, ls, pv, en};
    endfunction

    function automatic bit model(logic [31:0] v, logic [31:0] c, logic [31:0] a,
                                 logic [7:0] ln, bit ld, bit st, bit pr, bit lm);
        logic [7:0] bs;
        logic [7:0] sel;
        int mk;
        bs = c[12:5];
        mk = int'(c[28:24]);
        if (!c[0]) return 0;
        case (c[2:1])
            2'b01: if (!pr) return 0;
            2'b10: if (pr) return 0;
            2'b11: ;
            default: return 0;
        endcase
        case (c[4:3])
            2'b01: if (!ld) return 0;
            2'b10: if (!st) return 0;
            2'b11: if (!(ld || st)) return 0;
            default: return 0;
        endcase
        if (c[20] && !lm) return 0;
        if (ln == 0) return 0;
        if (mk == 0) begin
            if ((a >> 3) != (v >> 3)) return 0;
            sel = v[2] ? {bs[3:0], 4'h0} : bs;
            return |(sel & ln);
        end
        if (mk < 3 || bs != 8'hFF) return 0;
        return (a >> mk) == (v >> mk);
    endfunction

    task automatic check(bit got, bit exp, string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b (val=%h ctrl=%h addr=%h lanes=%h)",
                     req, got, exp, m_val, m_ctrl, acc_addr, acc_lanes);
        end
    endtask

    task automatic wr(bit sel, logic [31:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (sel) m_ctrl = d; else m_val = d;
    endtask

    task automatic access(logic [31:0] a, logic [7:0] ln, bit ld, bit st, bit pr,
                          bit lm, string req);
        bit exp;
        acc_valid = 1'b1; acc_addr = a; acc_lanes = ln;
        acc_load = ld; acc_store = st; acc_priv = pr; link_match = lm;
        exp = model(m_val, m_ctrl, a, ln, ld, st, pr, lm);
        @(negedge clk);
        check(wp_event, exp, req);
        acc_valid = 1'b0;
        @(negedge clk);
        check(wp_event, 1'b0, "R10 pulse ends");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL R10 watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(wp_event, 1'b0, "R1 event after reset");
        total++;
        if (link_bp_sel !== 4'd0) begin
            bad++; $display("FAIL R1: link_bp_sel got %0d expected 0", link_bp_sel);
        end
        rst_n = 1'b1;
        @(negedge clk);
        access(32'h0, 8'hFF, 1, 1, 1, 1, "R1 disabled after reset");

        // R5 word select
        wr(0, 32'h1000);
        wr(1, mk_ctrl(1, 2'b11, 2'b11, 8'h01, 4'd0, 0, 5'd0));
        access(32'h1000, 8'h01, 1, 0, 0, 0, "R5 lane0 hit");
        access(32'h1000, 8'h02, 1, 0, 0, 0, "R5 lane1 miss");
        access(32'h1008, 8'h01, 1, 0, 0, 0, "R5 other dword miss");
        // R5 upper word via value bit 2
        wr(0, 32'h1004);
        access(32'h1004, 8'h10, 0, 1, 0, 0, "R5 upper word hit");
        access(32'h1000, 8'h01, 0, 1, 0, 0, "R5 lower lane miss");
        // R5 upper select bits
        wr(0, 32'h1000);
        wr(1, mk_ctrl(1, 2'b11, 2'b11, 8'hF0, 4'd0, 0, 5'd0));
        access(32'h1007, 8'h80, 1, 0, 1, 0, "R5 lane7 hit");
        // R6
        wr(1, mk_ctrl(1, 2'b11, 2'b11, 8'h00, 4'd0, 0, 5'd0));
        access(32'h1000, 8'hFF, 1, 1, 1, 0, "R6 zero select");
        // R3
        wr(1, mk_ctrl(1, 2'b01, 2'b11, 8'hFF, 4'd0, 0, 5'd0));
        access(32'h1000, 8'h01, 1, 0, 0, 0, "R3 user on priv-only");
        access(32'h1000, 8'h01, 1, 0, 1, 0, "R3 priv on priv-only");
        wr(1, mk_ctrl(1, 2'b10, 2'b11, 8'hFF, 4'd0, 0, 5'd0));
        access(32'h1000, 8'h01, 1, 0, 1, 0, "R3 priv on user-only");
        wr(1, mk_ctrl(1, 2'b00, 2'b11, 8'hFF, 4'd0, 0, 5'd0));
        access(32'h1000, 8'h01, 1, 0, 1, 0, "R3 reserved");
        // R4
        wr(1, mk_ctrl(1, 2'b11, 2'b10, 8'hFF, 4'd0, 0, 5'd0));
        access(32'h1000, 8'h01, 1, 0, 0, 0, "R4 load on store-only");
        access(32'h1000, 8'h01, 1, 1, 0, 0, "R4 swap on store-only");
        wr(1, mk_ctrl(1, 2'b11, 2'b00, 8'hFF, 4'd0, 0, 5'd0));
        access(32'h1000, 8'h01, 1, 1, 0, 0, "R4 reserved");
        // R7
        wr(0, 32'h2000);
        wr(1, mk_ctrl(1, 2'b11, 2'b11, 8'hFF, 4'd0, 0, 5'd5));
        access(32'h201C, 8'h01, 1, 0, 0, 0, "R7 inside range");
        access(32'h2020, 8'h01, 1, 0, 0, 0, "R7 outside range");
        access(32'h2004, 8'h00, 1, 0, 0, 0, "R7 no lanes");
        wr(1, mk_ctrl(1, 2'b11, 2'b11, 8'hFF, 4'd0, 0, 5'd2));
        access(32'h2000, 8'h01, 1, 0, 0, 0, "R7 reserved mask");
        wr(1, mk_ctrl(1, 2'b11, 2'b11, 8'h0F, 4'd0, 0, 5'd5));
        access(32'h2000, 8'h01, 1, 0, 0, 0, "R7 mask without full select");
        wr(0, 32'h0);
        wr(1, mk_ctrl(1, 2'b11, 2'b11, 8'hFF, 4'd0, 0, 5'd31));
        access(32'h7FFF_FFF0, 8'h01, 1, 0, 0, 0, "R7 mask 31 hit");
        access(32'h8000_0000, 8'h01, 1, 0, 0, 0, "R7 mask 31 miss");
        // R8 / R9
        wr(0, 32'h1000);
        wr(1, mk_ctrl(1, 2'b11, 2'b11, 8'hFF, 4'd9, 1, 5'd0));
        total++;
        if (link_bp_sel !== 4'd9) begin
            bad++; $display("FAIL R9: link_bp_sel got %0d expected 9", link_bp_sel);
        end
        access(32'h1000, 8'h01, 1, 0, 0, 0, "R8 link no match");
        access(32'h1000, 8'h01, 1, 0, 0, 1, "R8 link match");
        // R2
        wr(1, mk_ctrl(0, 2'b11, 2'b11, 8'hFF, 4'd0, 0, 5'd0));
        access(32'h1000, 8'hFF, 1, 1, 1, 1, "R2 disabled");

        // constrained random
        for (int k = 0; k < 1500; k++) begin
            if (k % 20 == 0) begin
                logic [7:0] bs;
                logic [4:0] mk;
                logic [3:0] lbp;
                mk = ($urandom % 2 == 0) ? 5'd0 : 5'($urandom % 32);
                case ($urandom % 4)
                    0: bs = 8'h00;
                    1, 2: bs = 8'hFF;
                    default: bs = 8'($urandom);
                endcase
                if (mk != 0 && $urandom % 5 != 0) bs = 8'hFF;
                lbp = 4'($urandom);
                wr(0, $urandom);
                wr(1, mk_ctrl(($urandom % 8) != 0, 2'($urandom), 2'($urandom), bs,
                              lbp, $urandom % 3 == 0, mk));
                total++;
                if (link_bp_sel !== lbp) begin
                    bad++;
                    $display("FAIL R9: link_bp_sel got %0d expected %0d", link_bp_sel, lbp);
                end
            end
            begin
                logic [31:0] flip;
                case ($urandom % 4)
                    0: flip = $urandom & 32'h7;
                    1: flip = $urandom & 32'h3F;
                    2: flip = $urandom & 32'hFFFF;
                    default: flip = $urandom;
                endcase
                access(m_val ^ flip, 8'($urandom), $urandom % 2 == 1, $urandom % 2 == 1,
                       $urandom % 2 == 1, $urandom % 2 == 1, "R5/R7 random");
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule